// File: doc/BRIEF.md
# Radix-4 Four-Path Delay Commutator

This block sits between two radix-4 butterfly stages of a pipelined FFT and regroups a four-wide sample stream. Every accepted beat carries four complex samples, one per lane, and every delivered beat carries four complex samples. The regrouping makes sure that, in each delivered beat, the four lanes hold exactly the four operands that the next radix-4 butterfly combines, so that no butterfly input ever waits for data.

Internally, input lane k is delayed by k·SPAN beats, a 4x4 switch reorders the lanes by an amount that advances once every SPAN beats, and output lane j is delayed by a further (3−j)·SPAN beats. Seen from the ports, the block performs a 4x4 block transpose over windows of 4·SPAN beats. All delays count accepted beats, not clock cycles, so stalls on either side never disturb the ordering. A 1024-point transform built from four-wide stages uses spans of 64, 16, 4 and 1. When the transform is split into two independent lanes, each lane gets its own instance with half the span.

Both stream sides use a valid/ready handshake. A beat is accepted when `in_valid` and `in_ready` are both high on a rising clock edge. A delivered beat is consumed when `out_valid` and `out_ready` are both high. The output side is one register deep: `in_ready` is high whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held and no input is accepted.

Top module: `fdc_commutator`

## Requirements
- R1: Each lane word is 32 bits, with the real part in bits 31:16 and the imaginary part in bits 15:0. Words are moved without any change to their bits.
- R2: Number the accepted input beats n = 0, 1, 2, … from reset. Output beat T (counted from 0) carries, on lane j, the word that entered on lane s = ⌊T/SPAN⌋ mod 4 at input beat 4·SPAN·⌊T/(4·SPAN)⌋ + j·SPAN + (T mod SPAN).
- R3: No output beat is offered before 3·SPAN+1 input beats have been accepted. Output beat T becomes valid on the clock edge that accepts input beat 3·SPAN+T.
- R4: Clock cycles without an accepted input beat do not advance the delays or the switch. A rise of `out_valid` only ever follows an accepted input beat.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R6: Synchronous reset clears `out_valid`, the beat counter and the priming state. After reset, R2 and R3 apply again to the new stream, and no word accepted before the reset ever reaches the output.
- R7: With `in_valid` and `out_ready` held high, once primed, `out_valid` is high on every cycle: one group of four words is produced per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken this cycle |
| in_data | input | 4x32 | Four complex input words, lane k at [k] |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 4x32 | Four regrouped complex words, lane j at [j] |

## Verification
The hardest situation to reach is a stall that falls exactly on a boundary where the switch phase changes, or in the middle of the 3·SPAN priming window, while the output side is also applying back-pressure. With ordinary stimulus, these stalls fall elsewhere, so a miscount of beats against clock cycles would not show up. The bench therefore uses a small span and drives long runs in which a pseudo-random sequence gates both `in_valid` and `out_ready` independently. This makes stalls land on every phase offset many times over. A reset is applied in the middle of a stream with stale words still inside the delay lines. Each word carries its beat index, lane and run tag, so the mapping of R2 can be computed arithmetically for every output lane.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int NLANE  = 4;
  localparam int PART_W = 16;
  localparam int WORD_W = 2 * PART_W;

  typedef struct packed {
    logic [PART_W-1:0] re;
    logic [PART_W-1:0] im;
  } csample_t;

  typedef csample_t [NLANE-1:0] group_t;
endpackage

// File: rtl/fdc_delay_line.sv
module fdc_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_taps
      logic [W-1:0] taps [DEPTH];
      always_ff @(posedge clk) begin
        if (adv) begin
          taps[0] <= d;
          for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
      end
      assign q = taps[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fdc_rotator.sv
module fdc_rotator #(
  parameter int W = 32
) (
  input  logic [1:0]        phase,
  input  logic [3:0][W-1:0] a,
  output logic [3:0][W-1:0] y
);
  // Lane j takes lane (phase - j) mod 4: a rotation of the reversed lane order.
  for (genvar j = 0; j < 4; j++) begin : g_sel
    logic [1:0] src;
    assign src  = phase - 2'(j);
    assign y[j] = a[src];
  end
endmodule

// File: rtl/fdc_beat_ctrl.sv
module fdc_beat_ctrl #(
  parameter int SPAN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       out_ready,
  output logic       in_ready,
  output logic       adv,
  output logic [1:0] phase,
  output logic       out_valid
);
  localparam int CW       = $clog2(4 * SPAN);
  localparam int PRIME_AT = 3 * SPAN - 1;

  logic [CW-1:0] cnt;
  logic          primed;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;
  assign phase    = cnt[CW-1:CW-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      primed    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (adv) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(PRIME_AT)) primed <= 1'b1;
        out_valid <= primed;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fdc_commutator.sv
module fdc_commutator #(
  parameter int SPAN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0][31:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0][31:0] out_data
);
  import fdc_pkg::*;

  localparam int W = WORD_W;

  logic             adv;
  logic [1:0]       phase;
  logic [3:0][W-1:0] pre_sw, post_sw, aligned;

  fdc_beat_ctrl #(.SPAN(SPAN)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .adv(adv), .phase(phase), .out_valid(out_valid)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_in
    fdc_delay_line #(.W(W), .DEPTH(k * SPAN)) u_dl (
      .clk(clk), .adv(adv), .d(in_data[k]), .q(pre_sw[k])
    );
  end

  fdc_rotator #(.W(W)) u_rot (.phase(phase), .a(pre_sw), .y(post_sw));

  for (genvar j = 0; j < NLANE; j++) begin : g_out
    fdc_delay_line #(.W(W), .DEPTH((NLANE - 1 - j) * SPAN)) u_dl (
      .clk(clk), .adv(adv), .d(post_sw[j]), .q(aligned[j])
    );
  end

  always_ff @(posedge clk) begin
    if (adv) out_data <= aligned;
  end
endmodule

// File: rtl/fdc_commutator_chk.sv
module fdc_commutator_chk #(
  parameter int SPAN = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [3:0][31:0] out_data
);
  localparam int LIM = 3 * SPAN + 1;
  localparam int AW  = $clog2(LIM + 1);

  logic [AW-1:0] taken;
  logic          rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) taken <= '0;
    else if (in_valid && in_ready && taken != AW'(LIM)) taken <= taken + 1'b1;
  end

  // R6: one cycle after reset is seen, nothing is offered
  always_ff @(posedge clk) begin
    if (rst_q) assert_reset_clear_R6: assert (!out_valid);
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_no_early_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> taken == AW'(LIM));

  assert_rise_after_beat_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind fdc_commutator fdc_commutator_chk #(.SPAN(SPAN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_fdc_commutator.sv
module sim_fdc_commutator;
  localparam int SPAN = 4;
  localparam int D4   = 4 * SPAN;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid, in_ready, out_valid, out_ready;
  logic [3:0][31:0] in_data, out_data;

  fdc_commutator #(.SPAN(SPAN)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int          n_vec = 0, n_bad = 0;
  int          nin = 0, nout = 0, run = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic             prev_hold = 1'b0;
  logic [3:0][31:0] prev_data;

  function automatic logic [31:0] word_of(int beat, int lane, int r);
    return {16'(beat), 16'(r * 16 + lane)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (out beat %0d)", req, act, exp, nout);
    end
  endtask

  function automatic logic [15:0] step_lfsr(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // mode: 0 continuous, 1 input stalls, 2 both sides random
  task automatic run_cycles(int cycles, int mode);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      lfsr      = step_lfsr(lfsr);
      in_valid  = (mode == 0) ? 1'b1 : (lfsr[2:0] != 3'd0 && lfsr[5]);
      out_ready = (mode == 2) ? (lfsr[9:8] != 2'd0) : 1'b1;
      for (int k = 0; k < 4; k++) in_data[k] = word_of(nin, k, run);
      #1;
      // R5: ready rule and hold of a blocked beat
      chk("R5 ready", {31'd0, in_ready}, {31'd0, !out_valid || out_ready});
      if (prev_hold) begin
        chk("R5 hold valid", {31'd0, out_valid}, 32'd1);
        for (int j = 0; j < 4; j++) chk("R5 hold data", out_data[j], prev_data[j]);
      end
      // R3: never early
      if (out_valid && nin < 3 * SPAN + 1)
        chk("R3 early", {31'd0, out_valid}, 32'd0);
      // R7: full throughput once primed
      if (mode == 0 && nin >= 3 * SPAN + 1)
        chk("R7 throughput", {31'd0, out_valid}, 32'd1);
      if (out_valid && out_ready) begin
        // R2/R1: transpose mapping with unaltered words
        for (int j = 0; j < 4; j++) begin
          int s, src;
          s   = (nout / SPAN) % 4;
          src = (nout / D4) * D4 + j * SPAN + (nout % SPAN);
          chk("R2 map", out_data[j], word_of(src, s, run));
        end
        nout++;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (in_valid && in_ready) nin++;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
    repeat (3) @(negedge clk);
    #1 chk("R6 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R5 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst = 1'b0;
    run_cycles(150, 0);
    run_cycles(400, 1);
    run_cycles(600, 2);
    // R6: reset mid-stream with stale data in the delay lines
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    #1 chk("R6 mid reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    nin = 0; nout = 0; run = 1; prev_hold = 1'b0;
    run_cycles(5, 1);
    chk("R6 reprime", {31'd0, out_valid}, 32'd0);
    run_cycles(120, 0);
    run_cycles(500, 2);
    // R4: idle input cycles do not move the stream
    run_cycles(100, 1);
    if (nout == 0) chk("R3 outputs seen", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule